// File: doc/BRIEF.md
# Load-Use Interlock Scoreboard

This block sits at the issue stage of a simple in-order pipeline and decides, one instruction at a time, whether the instruction on the issue port may go ahead. It tracks every register that is the target of a load whose data has not yet been written back. Each such register carries a lock and a small countdown. When a load issues, its destination register is locked for a fixed latency of `LOAD_LAT` cycles (default 2). An instruction that reads a locked register as either source, or that writes one, holds the stall output high until the lock drops. Every other instruction keeps issuing in the shadow of the load, so an outstanding load does not freeze the pipeline.

Several loads to different registers can be outstanding at once, and each keeps its own countdown. A load completion event on a separate port releases a lock before its countdown runs out. This serves a memory system that answers early. Register 0 is hard-wired and is never locked. While the stall output is high, the issue side holds the same instruction on the port, and the scoreboard sets no lock for it. The stall output is a combinational function of the current issue request and the registered lock state.

Top module: `ldu_scoreboard`

## Requirements
- R1: After synchronous reset no register is locked, so any valid instruction sees stall low.
- R2: A load that issues (valid, load flag set, stall low) with a nonzero destination locks that register. A later valid instruction that names it in source A or source B sees stall high while the lock holds.
- R3: A load issued in cycle t keeps its register locked through cycle t+LOAD_LAT-1. The lock is gone in cycle t+LOAD_LAT, and a dependent instruction issues in that cycle with stall low.
- R4: A valid instruction whose two sources and destination are all unlocked sees stall low while other loads are outstanding, and may itself be a load.
- R5: A valid instruction, load or not, whose destination is a locked register sees stall high until that lock clears (write-after-write).
- R6: Register 0 is never locked. A load with destination 0 sets no lock, and an instruction using register 0 in any field never stalls because of it.
- R7: Loads to different registers issued in consecutive cycles are all outstanding together. Each one's lock clears LOAD_LAT cycles after its own issue.
- R8: An instruction that sees stall high sets no lock. A stalled load held on the port therefore issues with stall low as soon as its own dependency clears.
- R9: A completion event (valid, register number) for a locked register releases that lock at the next clock edge, ahead of its countdown.
- R10: A completion event for an unlocked register has no effect. A completion event in the same cycle as an issuing load to the same register loses, so the new lock is kept.
- R11: With the issue valid input low, stall is low whatever the register fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is presented on the issue port |
| iss_load | input | 1 | The presented instruction is a load |
| iss_src_a | input | RW | First source register number (0 when unused) |
| iss_src_b | input | RW | Second source register number (0 when unused) |
| iss_dst | input | RW | Destination register number (0 when none) |
| cpl_valid | input | 1 | A load completion event is present |
| cpl_reg | input | RW | Register whose load has completed |
| stall | output | 1 | High when the presented instruction must wait |

## Verification
The bench sets the load latency to three so that the lock window spans more than one cycle. It probes the exact first and last stall cycles. An off-by-one countdown would release the dependent one cycle early or late. A stalled load is held on the port to show that it locks nothing while waiting: a design that set the lock anyway would stall that load against its own destination. Register 0 is used as a load target and as a source, which would expose a missing zero exclusion. Completion events are sent to locked registers, to unlocked registers, and in the same cycle as a new load to that register. Wrong priority between set and release would drop the fresh lock, and a completion that failed to act would leave the dependent stalled.

// File: rtl/ldu_sb_pkg.sv
package ldu_sb_pkg;

  localparam int DEF_NREGS    = 32;
  localparam int DEF_LOAD_LAT = 2;

  // Bits needed to hold the largest countdown value (LOAD_LAT-1).
  function automatic int cnt_bits(input int lat);
    return (lat < 3) ? 1 : $clog2(lat);
  endfunction

endpackage

// File: rtl/ldu_onehot.sv
module ldu_onehot #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic         en,
  input  logic [W-1:0] idx,
  output logic [N-1:0] oh
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign oh[i] = en && (idx == W'(i));
  end

endmodule

// File: rtl/ldu_lock_cell.sv
module ldu_lock_cell #(
  parameter int LOAD_LAT = 2,
  parameter int CW       = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic done_i,
  output logic locked_o
);

  logic          lock_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else if (set_i) begin
      lock_q <= 1'b1;
      cnt_q  <= CW'(LOAD_LAT - 1);
    end else if (lock_q) begin
      if (done_i || cnt_q <= CW'(1)) begin
        lock_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q - CW'(1);
      end
    end
  end

  assign locked_o = lock_q;

  AST_SET_ON_FREE_ONLY: assert property (@(posedge clk) disable iff (rst)
    set_i |-> !lock_q);                                              // R8
  AST_SET_LOCKS: assert property (@(posedge clk) disable iff (rst)
    set_i |=> lock_q);                                               // R2
  AST_LAST_CYCLE_FREES: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !set_i && cnt_q == CW'(1)) |=> !lock_q);             // R3
  AST_DONE_FREES: assert property (@(posedge clk) disable iff (rst)
    (lock_q && done_i && !set_i) |=> !lock_q);                       // R9
  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lock_q |-> (cnt_q == '0));                                      // R3

endmodule

// File: rtl/ldu_hazard.sv
module ldu_hazard #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] locked_i,
  input  logic         valid_i,
  input  logic [W-1:0] src_a_i,
  input  logic [W-1:0] src_b_i,
  input  logic [W-1:0] dst_i,
  output logic         stall_o
);

  logic raw_a, raw_b, waw;

  always_comb begin
    raw_a   = locked_i[src_a_i];
    raw_b   = locked_i[src_b_i];
    waw     = locked_i[dst_i];
    stall_o = valid_i && (raw_a || raw_b || waw);
  end

endmodule

// File: rtl/ldu_scoreboard.sv
module ldu_scoreboard #(
  parameter int NREGS    = ldu_sb_pkg::DEF_NREGS,
  parameter int LOAD_LAT = ldu_sb_pkg::DEF_LOAD_LAT,
  parameter int RW       = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic          iss_load,
  input  logic [RW-1:0] iss_src_a,
  input  logic [RW-1:0] iss_src_b,
  input  logic [RW-1:0] iss_dst,
  input  logic          cpl_valid,
  input  logic [RW-1:0] cpl_reg,
  output logic          stall
);

  localparam int CW = ldu_sb_pkg::cnt_bits(LOAD_LAT);

  logic [NREGS-1:0] set_vec;
  logic [NREGS-1:0] done_vec;
  logic [NREGS-1:0] locked_vec;
  logic             stall_w;
  logic             set_en;

  // A lock is only taken by a load that actually issues to a real register.
  assign set_en = iss_valid && iss_load && !stall_w && (iss_dst != '0);

  ldu_onehot #(.N(NREGS), .W(RW)) u_set_dec (
    .en  (set_en),
    .idx (iss_dst),
    .oh  (set_vec)
  );

  ldu_onehot #(.N(NREGS), .W(RW)) u_done_dec (
    .en  (cpl_valid),
    .idx (cpl_reg),
    .oh  (done_vec)
  );

  for (genvar r = 0; r < NREGS; r++) begin : g_cell
    ldu_lock_cell #(.LOAD_LAT(LOAD_LAT), .CW(CW)) u_cell (
      .clk      (clk),
      .rst      (rst),
      .set_i    (set_vec[r]),
      .done_i   (done_vec[r]),
      .locked_o (locked_vec[r])
    );
  end

  ldu_hazard #(.N(NREGS), .W(RW)) u_hazard (
    .locked_i (locked_vec),
    .valid_i  (iss_valid),
    .src_a_i  (iss_src_a),
    .src_b_i  (iss_src_b),
    .dst_i    (iss_dst),
    .stall_o  (stall_w)
  );

  assign stall = stall_w;

  AST_ZERO_NEVER_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !locked_vec[0]);                                                  // R6
  AST_LOAD_USE_STALLS: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_load && !stall && iss_dst != '0)
      |=> (!(iss_valid && iss_src_a == $past(iss_dst)) || stall));    // R2
  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |-> !stall);                                           // R11

endmodule

// File: tb/ldu_scoreboard_test.sv
module ldu_scoreboard_test;

  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          iss_valid, iss_load, cpl_valid;
  logic [RW-1:0] iss_src_a, iss_src_b, iss_dst, cpl_reg;
  logic          stall;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #4ns clk = ~clk;

  ldu_scoreboard #(.NREGS(32), .LOAD_LAT(3)) uut (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_load(iss_load),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
    .cpl_valid(cpl_valid), .cpl_reg(cpl_reg),
    .stall(stall)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Drive one cycle's request at the falling edge, check stall, then let it clock.
  task automatic step(input logic v, input logic ld, input int a, input int b, input int d,
                      input logic cv, input int cr, input logic exp, input string req);
    @(negedge clk);
    iss_valid = v;  iss_load = ld;
    iss_src_a = RW'(a); iss_src_b = RW'(b); iss_dst = RW'(d);
    cpl_valid = cv; cpl_reg = RW'(cr);
    #1ns;
    total++;
    if (stall !== exp) begin
      bad++;
      $display("FAIL %s: stall=%0b expected %0b", req, stall, exp);
    end
  endtask

  task automatic quiet();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 1'b0, "R11 idle");
  endtask

  task automatic t_reset();
    step(1, 0, 5, 6, 7, 0, 0, 1'b0, "R1 no lock after reset");
    step(1, 0, 31, 1, 2, 0, 0, 1'b0, "R1 no lock after reset");
  endtask

  task automatic t_load_use();
    step(1, 1, 1, 2, 5, 0, 0, 1'b0, "R2 load r5 issues");
    step(1, 0, 5, 0, 8, 0, 0, 1'b1, "R2 reader of r5 stalls");
    step(1, 0, 5, 0, 8, 0, 0, 1'b1, "R3 still locked at t+2");
    step(1, 0, 5, 0, 8, 0, 0, 1'b0, "R3 free at t+LAT");
    quiet();
  endtask

  task automatic t_src_b_and_valid();
    step(1, 1, 0, 0, 7, 0, 0, 1'b0, "R2 load r7 issues");
    step(0, 0, 7, 7, 7, 0, 0, 1'b0, "R11 no stall without valid");
    step(1, 0, 3, 7, 9, 0, 0, 1'b1, "R2 source B hit stalls");
    step(1, 0, 3, 7, 9, 0, 0, 1'b0, "R3 source B free at t+LAT");
    quiet();
  endtask

  task automatic t_independent();
    step(1, 1, 0, 0, 10, 0, 0, 1'b0, "R4 load r10 issues");
    step(1, 0, 11, 12, 13, 0, 0, 1'b0, "R4 independent op issues");
    step(1, 1, 1, 0, 14, 0, 0, 1'b0, "R4 load in shadow issues");
    step(1, 0, 14, 0, 15, 0, 0, 1'b1, "R4 reader of r14 stalls");
    step(1, 0, 14, 0, 15, 0, 0, 1'b1, "R3 r14 still locked");
    step(1, 0, 14, 0, 15, 0, 0, 1'b0, "R3 r14 free");
    quiet();
  endtask

  task automatic t_waw();
    step(1, 1, 0, 0, 15, 0, 0, 1'b0, "R5 load r15 issues");
    step(1, 0, 1, 2, 15, 0, 0, 1'b1, "R5 ALU write to locked r15 stalls");
    step(1, 0, 1, 2, 15, 0, 0, 1'b1, "R5 still waiting");
    step(1, 0, 1, 2, 15, 0, 0, 1'b0, "R5 write issues after release");
    quiet();
    step(1, 1, 0, 0, 16, 0, 0, 1'b0, "R5 load r16 issues");
    step(1, 1, 0, 0, 16, 0, 0, 1'b1, "R5 second load to r16 stalls");
    step(1, 1, 0, 0, 16, 0, 0, 1'b1, "R5 second load waits");
    step(1, 1, 0, 0, 16, 0, 0, 1'b0, "R5 second load issues");
    step(1, 0, 16, 0, 0, 0, 0, 1'b1, "R5 second load relocked r16");
    quiet();
  endtask

  task automatic t_reg_zero();
    step(1, 1, 0, 0, 0, 0, 0, 1'b0, "R6 load to r0 issues");
    step(1, 0, 0, 0, 0, 0, 0, 1'b0, "R6 r0 never locked");
    step(1, 1, 0, 0, 0, 0, 0, 1'b0, "R6 repeated load to r0");
    quiet();
  endtask

  task automatic t_multi();
    step(1, 1, 0, 0, 1, 0, 0, 1'b0, "R7 load r1");
    step(1, 1, 0, 0, 2, 0, 0, 1'b0, "R7 load r2");
    step(1, 1, 0, 0, 3, 0, 0, 1'b0, "R7 load r3");
    step(1, 0, 1, 0, 0, 0, 0, 1'b0, "R7 r1 free first");
    step(1, 0, 3, 0, 0, 0, 0, 1'b1, "R7 r3 still locked");
    step(1, 0, 3, 0, 0, 0, 0, 1'b0, "R7 r3 free on its own count");
    quiet();
  endtask

  task automatic t_stalled_load();
    step(1, 1, 0, 0, 5, 0, 0, 1'b0, "R8 load r5 issues");
    step(1, 1, 5, 0, 6, 0, 0, 1'b1, "R8 dependent load stalls");
    step(1, 1, 5, 0, 6, 0, 0, 1'b1, "R8 dependent load held");
    step(1, 1, 5, 0, 6, 0, 0, 1'b0, "R8 held load not self-locked");
    step(1, 0, 6, 0, 0, 0, 0, 1'b1, "R8 r6 locked after issue");
    step(1, 0, 6, 0, 0, 0, 0, 1'b1, "R8 r6 still locked");
    step(1, 0, 6, 0, 0, 0, 0, 1'b0, "R8 r6 free");
    quiet();
  endtask

  task automatic t_completion();
    step(1, 1, 0, 0, 9, 0, 0, 1'b0, "R9 load r9 issues");
    step(1, 0, 9, 0, 0, 1, 9, 1'b1, "R9 stall in completion cycle");
    step(1, 0, 9, 0, 0, 0, 0, 1'b0, "R9 early release");
    quiet();
    step(1, 1, 0, 0, 11, 0, 0, 1'b0, "R10 load r11 issues");
    step(1, 0, 11, 0, 0, 1, 10, 1'b1, "R10 completion for r10 only");
    step(1, 0, 11, 0, 0, 0, 0, 1'b1, "R10 r11 unaffected");
    step(1, 0, 11, 0, 0, 0, 0, 1'b0, "R10 r11 free on count");
    quiet();
  endtask

  task automatic t_race();
    step(1, 1, 0, 0, 12, 1, 12, 1'b0, "R10 load and completion same reg");
    step(1, 0, 12, 0, 0, 0, 0, 1'b1, "R10 new lock wins");
    step(1, 0, 12, 0, 0, 0, 0, 1'b1, "R10 lock held");
    step(1, 0, 12, 0, 0, 0, 0, 1'b0, "R10 lock released");
    quiet();
  endtask

  initial begin
    #1600us;
    bad++;
    $display("FAIL watchdog: run hung");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    iss_valid = 0; iss_load = 0; cpl_valid = 0;
    iss_src_a = '0; iss_src_b = '0; iss_dst = '0; cpl_reg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_use();
    t_src_b_and_valid();
    t_independent();
    t_waw();
    t_reg_zero();
    t_multi();
    t_stalled_load();
    t_completion();
    t_race();
    finish_run();
  end

endmodule